// File: doc/BRIEF.md
# Shared Cache Tag Controller with Inclusion-Locked Replacement

This block is the tag and replacement controller of a unified, set-associative second-level cache that several cores share. Each core has its own instruction and data first-level caches. A build-time parameter selects which one of the two sides is inclusive in the shared cache. For every shared line the controller keeps a presence vector with one bit per core. A bit is set while that core's inclusive private cache holds the line. A line with any presence bit set is locked: no fill from any core can choose it as a victim. Lines held only on the non-inclusive side get no such protection.

Requests arrive one per cycle on a single port that carries a core number. The operations are a lookup, a fill, an eviction notice from a core's inclusive private cache, a clean-and-invalidate of one address, and an invalidate-all of one core's instruction cache. Each request is answered one cycle later with hit, way, bypass, replaced-line and back-invalidate information. A miss fill takes the lowest invalid way when one exists. Otherwise a free-running LFSR picks a starting way, and the controller takes the first unlocked way from there. When every way is locked the fill is not allocated and is flagged as a bypass. Data arrays and memory are outside this block.

Top module: `l2lk_ctrl`

## Requirements
- R1: Every request accepted with `req_valid` high is answered by `rsp_valid` high exactly one clock later, and no response appears in a cycle after an idle one.
- R2: Lookups are unified: a lookup from either side and any core hits when the tag is present, whichever side filled the line, and `rsp_way` names the way that holds it. Opcodes: 0 lookup, 1 fill, 2 eviction notice, 3 clean-and-invalidate, 4 instruction invalidate-all. `req_side` is 1 for instruction and 0 for data. The address is {tag, set index}, with the index in the low bits.
- R3: A miss fill into a set that has an invalid way allocates the lowest-numbered invalid way and reports `rsp_evict` low.
- R4: A way whose presence vector is non-zero is never chosen as the victim of a fill, whatever the issuing core or side.
- R5: A miss fill into a set whose ways are all locked sets `rsp_bypass` and allocates nothing, so a later lookup of that address misses. Hit and bypass are never both high.
- R6: Lines filled only on the non-inclusive side (data, by default) are not locked. A fill by another core into a full set of such lines replaces exactly one of them and reports `rsp_evict` high.
- R7: An eviction notice from a core on the inclusive side that hits clears that core's presence bit. This lets later fills, including the same core's own, replace the line.
- R8: Presence is tracked per core. A line held by two cores stays locked until both have sent eviction notices.
- R9: Clean-and-invalidate removes the addressed line from the shared cache. It also raises `binv_valid` with `binv_instr` low and `binv_mask` all ones, so the data caches of every core are back-invalidated.
- R10: Instruction invalidate-all raises `binv_valid` with `binv_instr` high and a one-hot `binv_mask` naming only the issuing core. When the instruction side is inclusive, it clears that core's presence bits in every line and leaves other cores' bits unchanged.
- R11: After reset no line is valid, so every lookup misses, and `rsp_valid` and `binv_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code |
| req_core | input | CORE_W | Issuing core number |
| req_side | input | 1 | 1 = instruction side, 0 = data side |
| req_addr | input | TAG_W+SET_W | Line address {tag, set index} |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_hit | output | 1 | Address was present in the shared cache |
| rsp_way | output | WAY_W | Hit way, or allocated way on a miss fill |
| rsp_bypass | output | 1 | Miss fill not allocated: all ways locked |
| rsp_evict | output | 1 | Allocation replaced a valid line |
| binv_valid | output | 1 | Back-invalidate to private caches |
| binv_instr | output | 1 | Back-invalidate targets instruction caches (else data) |
| binv_mask | output | NCORES | Cores whose private cache is back-invalidated |

## Verification
Every result of this block comes from one register stage. The hit, way, bypass, replacement and back-invalidate fields of a request therefore appear exactly one rising edge after the edge that samples it. The tag and presence state changes on that same edge, so the very next request already sees the effect. The bench drives each request on a falling edge and pushes its expected fields into a queue. A monitor pops and compares one entry on every following falling edge that shows `rsp_valid`. The LFSR decides victims only when several ways are unlocked. In those cases the bench checks just the LFSR-independent facts: no bypass, a valid line replaced, the right number of surviving hits, and locked lines still present.

// File: rtl/l2lk_pkg.sv
package l2lk_pkg;

  typedef enum logic [2:0] {
    OP_LOOKUP = 3'd0,
    OP_FILL   = 3'd1,
    OP_EVNOTE = 3'd2,
    OP_CLEAN  = 3'd3,
    OP_IINV   = 3'd4
  } l2lk_op_e;

  localparam logic SIDE_DATA  = 1'b0;
  localparam logic SIDE_INSTR = 1'b1;

endpackage

// File: rtl/l2lk_lfsr.sv
module l2lk_lfsr #(
  parameter int LFSR_W = 8,
  parameter int OUT_W  = 2,
  parameter logic [LFSR_W-1:0] TAPS = 8'hB8,
  parameter logic [LFSR_W-1:0] SEED = 8'h5A
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd
);

  logic [LFSR_W-1:0] state_q;

  function automatic logic [LFSR_W-1:0] step(input logic [LFSR_W-1:0] s);
    step = s[0] ? ((s >> 1) ^ TAPS) : (s >> 1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= step(state_q);
  end

  assign rnd = state_q[OUT_W-1:0];

endmodule

// File: rtl/l2lk_tag_store.sv
module l2lk_tag_store #(
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  parameter int NCORES = 2,
  parameter int TAG_W  = 6,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  rd_idx,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic [WAYS-1:0]   hit_vec,
  output logic [WAYS-1:0]   valid_vec,
  output logic [WAYS-1:0]   prot_vec,
  input  logic              alloc_en,
  input  logic [WAY_W-1:0]  alloc_way,
  input  logic [NCORES-1:0] alloc_pres,
  input  logic              pres_set_en,
  input  logic              pres_clr_en,
  input  logic [WAY_W-1:0]  pres_way,
  input  logic [NCORES-1:0] pres_core_oh,
  input  logic              inv_en,
  input  logic [WAY_W-1:0]  inv_way,
  input  logic              core_clr_en,
  input  logic [NCORES-1:0] core_clr_oh
);

  logic [WAYS-1:0]   valid_q [SETS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [NCORES-1:0] pres_q  [SETS][WAYS];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      valid_vec[w] = valid_q[rd_idx][w];
      hit_vec[w]   = valid_q[rd_idx][w] && (tag_q[rd_idx][w] == rd_tag);
      prot_vec[w]  = |pres_q[rd_idx][w];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w]  <= '0;
          pres_q[s][w] <= '0;
        end
      end
    end else begin
      if (core_clr_en) begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++)
            pres_q[s][w] <= pres_q[s][w] & ~core_clr_oh;
      end
      if (alloc_en) begin
        valid_q[rd_idx][alloc_way] <= 1'b1;
        tag_q[rd_idx][alloc_way]   <= rd_tag;
        pres_q[rd_idx][alloc_way]  <= alloc_pres;
      end
      if (pres_set_en)
        pres_q[rd_idx][pres_way] <= pres_q[rd_idx][pres_way] | pres_core_oh;
      if (pres_clr_en)
        pres_q[rd_idx][pres_way] <= pres_q[rd_idx][pres_way] & ~pres_core_oh;
      if (inv_en) begin
        valid_q[rd_idx][inv_way] <= 1'b0;
        pres_q[rd_idx][inv_way]  <= '0;
      end
    end
  end

endmodule

// File: rtl/l2lk_victim_sel.sv
module l2lk_victim_sel #(
  parameter int WAYS = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]  valid_vec,
  input  logic [WAYS-1:0]  prot_vec,
  input  logic [WAY_W-1:0] start,
  output logic             vic_ok,
  output logic [WAY_W-1:0] vic_way
);

  // Lowest invalid way wins; otherwise rotate from start to the first unlocked way.
  function automatic logic [WAY_W-1:0] pick(input logic [WAYS-1:0] vld,
                                            input logic [WAYS-1:0] prt,
                                            input logic [WAY_W-1:0] st);
    logic             found;
    logic [WAY_W-1:0] w;
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!found && !vld[i]) begin
        found = 1'b1;
        pick  = WAY_W'(i);
      end
    end
    for (int k = 0; k < WAYS; k++) begin
      w = st + WAY_W'(k);
      if (!found && !prt[w]) begin
        found = 1'b1;
        pick  = w;
      end
    end
  endfunction

  assign vic_ok  = |(~prot_vec);
  assign vic_way = pick(valid_vec, prot_vec, start);

endmodule

// File: rtl/l2lk_ctrl.sv
module l2lk_ctrl
  import l2lk_pkg::*;
#(
  parameter int   SETS       = 4,
  parameter int   WAYS       = 4,
  parameter int   NCORES     = 2,
  parameter int   TAG_W      = 6,
  parameter logic INCL_INSTR = 1'b1,
  localparam int  SET_W  = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int  WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int  CORE_W = (NCORES > 1) ? $clog2(NCORES) : 1,
  localparam int  ADDR_W = TAG_W + SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [CORE_W-1:0] req_core,
  input  logic              req_side,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic              rsp_bypass,
  output logic              rsp_evict,
  output logic              binv_valid,
  output logic              binv_instr,
  output logic [NCORES-1:0] binv_mask
);

  function automatic logic [NCORES-1:0] core_onehot(input logic [CORE_W-1:0] c);
    core_onehot = NCORES'(1) << c;
  endfunction

  function automatic logic [WAY_W-1:0] way_encode(input logic [WAYS-1:0] v);
    way_encode = '0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (v[i]) way_encode = WAY_W'(i);
  endfunction

  logic [SET_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [WAYS-1:0]   hit_vec, valid_vec, prot_vec;
  logic              hit;
  logic [WAY_W-1:0]  hit_way;
  logic [WAY_W-1:0]  rnd;
  logic              vic_ok;
  logic [WAY_W-1:0]  vic_way;
  logic [NCORES-1:0] core_oh;
  logic              incl_req;

  // Named events, also watched by the checker.
  logic is_lookup, is_fill, is_evnote, is_clean, is_iinv;
  logic ev_alloc, ev_bypass, ev_pres_set, ev_pres_clr, ev_inv, ev_core_clr;

  assign idx      = req_addr[SET_W-1:0];
  assign tag      = req_addr[ADDR_W-1:SET_W];
  assign hit      = |hit_vec;
  assign hit_way  = way_encode(hit_vec);
  assign core_oh  = core_onehot(req_core);
  assign incl_req = (req_side == INCL_INSTR);

  assign is_lookup = req_valid && (req_op == OP_LOOKUP);
  assign is_fill   = req_valid && (req_op == OP_FILL);
  assign is_evnote = req_valid && (req_op == OP_EVNOTE);
  assign is_clean  = req_valid && (req_op == OP_CLEAN);
  assign is_iinv   = req_valid && (req_op == OP_IINV);

  assign ev_alloc    = is_fill && !hit && vic_ok;
  assign ev_bypass   = is_fill && !hit && !vic_ok;
  assign ev_pres_set = is_fill && hit && incl_req;
  assign ev_pres_clr = is_evnote && hit && incl_req;
  assign ev_inv      = is_clean && hit;
  assign ev_core_clr = is_iinv && (INCL_INSTR == SIDE_INSTR);

  l2lk_lfsr #(.LFSR_W(8), .OUT_W(WAY_W)) u_lfsr (
    .clk (clk),
    .rst_n (rst_n),
    .rnd (rnd)
  );

  l2lk_tag_store #(
    .SETS(SETS), .WAYS(WAYS), .NCORES(NCORES), .TAG_W(TAG_W)
  ) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_idx       (idx),
    .rd_tag       (tag),
    .hit_vec      (hit_vec),
    .valid_vec    (valid_vec),
    .prot_vec     (prot_vec),
    .alloc_en     (ev_alloc),
    .alloc_way    (vic_way),
    .alloc_pres   (incl_req ? core_oh : '0),
    .pres_set_en  (ev_pres_set),
    .pres_clr_en  (ev_pres_clr),
    .pres_way     (hit_way),
    .pres_core_oh (core_oh),
    .inv_en       (ev_inv),
    .inv_way      (hit_way),
    .core_clr_en  (ev_core_clr),
    .core_clr_oh  (core_oh)
  );

  l2lk_victim_sel #(.WAYS(WAYS)) u_vic (
    .valid_vec (valid_vec),
    .prot_vec  (prot_vec),
    .start     (rnd),
    .vic_ok    (vic_ok),
    .vic_way   (vic_way)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_way    <= '0;
      rsp_bypass <= 1'b0;
      rsp_evict  <= 1'b0;
      binv_valid <= 1'b0;
      binv_instr <= 1'b0;
      binv_mask  <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_hit    <= (is_lookup || is_fill || is_evnote || is_clean) && hit;
      rsp_way    <= hit ? hit_way : (ev_alloc ? vic_way : '0);
      rsp_bypass <= ev_bypass;
      rsp_evict  <= ev_alloc && valid_vec[vic_way];
      binv_valid <= is_clean || is_iinv;
      binv_instr <= is_iinv;
      binv_mask  <= is_clean ? '1 : (is_iinv ? core_oh : '0);
    end
  end

endmodule

// File: rtl/l2lk_ctrl_chk.sv
module l2lk_ctrl_chk #(
  parameter int WAYS   = 4,
  parameter int NCORES = 2,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_bypass,
  input logic              binv_valid,
  input logic              binv_instr,
  input logic [NCORES-1:0] binv_mask,
  input logic              ev_alloc,
  input logic              ev_bypass,
  input logic [WAY_W-1:0]  vic_way,
  input logic [WAYS-1:0]   prot_vec
);

  a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r4_victim_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alloc |-> !prot_vec[vic_way]);

  a_r5_bypass_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bypass |-> (&prot_vec));

  a_r5_hit_excl_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_hit && rsp_bypass));

  a_r9_clean_all_cores: assert property (@(posedge clk) disable iff (!rst_n)
    (binv_valid && !binv_instr) |-> (&binv_mask));

  a_r10_iinv_one_core: assert property (@(posedge clk) disable iff (!rst_n)
    (binv_valid && binv_instr) |-> ($countones(binv_mask) == 1));

  a_r11_binv_needs_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    binv_valid |-> rsp_valid);

endmodule

bind l2lk_ctrl l2lk_ctrl_chk #(.WAYS(WAYS), .NCORES(NCORES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_bypass (rsp_bypass),
  .binv_valid (binv_valid),
  .binv_instr (binv_instr),
  .binv_mask  (binv_mask),
  .ev_alloc   (ev_alloc),
  .ev_bypass  (ev_bypass),
  .vic_way    (vic_way),
  .prot_vec   (prot_vec)
);

// File: tb/l2lk_ctrl_bench.sv
module l2lk_ctrl_bench;

  localparam int SETS = 4, WAYS = 4, NCORES = 2, TAG_W = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [0:0] req_core = '0;
  logic       req_side = 1'b0;
  logic [7:0] req_addr = '0;
  logic       rsp_valid, rsp_hit, rsp_bypass, rsp_evict;
  logic [1:0] rsp_way;
  logic       binv_valid, binv_instr;
  logic [1:0] binv_mask;

  always #2.5 clk = ~clk;

  l2lk_ctrl #(.SETS(SETS), .WAYS(WAYS), .NCORES(NCORES), .TAG_W(TAG_W)) u_l2lk_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_core(req_core), .req_side(req_side), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .rsp_bypass(rsp_bypass), .rsp_evict(rsp_evict), .binv_valid(binv_valid),
    .binv_instr(binv_instr), .binv_mask(binv_mask)
  );

  typedef struct {
    bit         chk_hit;  bit exp_hit;
    bit         chk_way;  int exp_way;
    bit         exp_byp;
    bit         chk_ev;   bit exp_ev;
    bit         exp_binv; bit exp_binvi; int exp_mask;
    string      tag;
  } exp_t;

  exp_t q[$];
  int nchk = 0, nerr = 0, hits_seen = 0;

  function automatic void check(bit ok, string tag, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endfunction

  function automatic int ad(int t, int s);
    return t * 4 + s;
  endfunction

  task automatic send(int op, int core, int side, int addr, exp_t e);
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = 3'(op);
    req_core  = 1'(core);
    req_side  = side[0];
    req_addr  = 8'(addr);
    q.push_back(e);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic exp_t mk(bit ch, bit h, bit cw, int w, bit b, bit ce, bit ev, string tag);
    exp_t e;
    e.chk_hit = ch; e.exp_hit = h; e.chk_way = cw; e.exp_way = w; e.exp_byp = b;
    e.chk_ev = ce; e.exp_ev = ev; e.exp_binv = 0; e.exp_binvi = 0; e.exp_mask = 0;
    e.tag = tag;
    return e;
  endfunction

  // op codes: 0 lookup, 1 fill, 2 eviction notice, 3 clean-inv, 4 instr inv-all
  task automatic lk(int c, int s, int a, bit h, int w, string tag);
    send(0, c, s, a, mk(1, h, h, w, 0, 1, 0, tag));
  endtask
  task automatic fl(int c, int s, int a, bit h, bit cw, int w, bit b, bit ce, bit ev, string tag);
    send(1, c, s, a, mk(1, h, cw, w, b, ce, ev, tag));
  endtask
  task automatic evn(int c, int s, int a, int w, string tag);
    send(2, c, s, a, mk(1, 1, 1, w, 0, 1, 0, tag));
  endtask

  // Monitor: compares each response against the oldest expected entry.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q.size() == 0) begin
        check(0, "R1", "unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        hits_seen += int'(rsp_hit);
        if (e.chk_hit) check(rsp_hit == e.exp_hit, e.tag, "hit", rsp_hit, e.exp_hit);
        if (e.chk_way) check(int'(rsp_way) == e.exp_way, e.tag, "way", rsp_way, e.exp_way);
        check(rsp_bypass == e.exp_byp, e.tag, "bypass", rsp_bypass, e.exp_byp);
        if (e.chk_ev) check(rsp_evict == e.exp_ev, e.tag, "evict", rsp_evict, e.exp_ev);
        check(binv_valid == e.exp_binv, e.tag, "binv_valid", binv_valid, e.exp_binv);
        if (e.exp_binv) begin
          check(binv_instr == e.exp_binvi, e.tag, "binv_instr", binv_instr, e.exp_binvi);
          check(int'(binv_mask) == e.exp_mask, e.tag, "binv_mask", binv_mask, e.exp_mask);
        end
      end
    end
  end

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    exp_t e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: idle after reset
    check(rsp_valid == 0, "R11", "rsp_valid", rsp_valid, 0);
    check(binv_valid == 0, "R11", "binv_valid", binv_valid, 0);
    lk(0, 1, ad(1, 1), 0, 0, "R11");

    // R3: instruction fills by core 0 take ways 0..3 in order
    for (int t = 1; t <= 4; t++) fl(0, 1, ad(t, 1), 0, 1, t - 1, 0, 1, 0, "R3");
    // R2: data-side lookup by another core hits an instruction-filled line
    lk(1, 0, ad(2, 1), 1, 1, "R2");
    // R5: all ways locked -> bypass, then miss
    fl(1, 0, ad(5, 1), 0, 0, 0, 1, 1, 0, "R5");
    lk(1, 0, ad(5, 1), 0, 0, "R5");
    // R8: core 1 also holds t3 (way 2)
    fl(1, 1, ad(3, 1), 1, 1, 2, 0, 1, 0, "R8");
    evn(0, 1, ad(3, 1), 2, "R8");
    fl(1, 0, ad(5, 1), 0, 0, 0, 1, 1, 0, "R8");
    // R7: last holder leaves, way 2 becomes the only candidate
    evn(1, 1, ad(3, 1), 2, "R7");
    fl(1, 1, ad(5, 1), 0, 1, 2, 0, 1, 1, "R4");
    lk(0, 0, ad(3, 1), 0, 0, "R7");
    // R7: same core evicts its own line after notice
    evn(0, 1, ad(1, 1), 0, "R7");
    fl(0, 1, ad(6, 1), 0, 1, 0, 0, 1, 1, "R7");
    // R9: clean-and-invalidate t2 (way 1)
    e = mk(1, 1, 1, 1, 0, 1, 0, "R9");
    e.exp_binv = 1; e.exp_binvi = 0; e.exp_mask = 3;
    send(3, 1, 0, ad(2, 1), e);
    lk(0, 0, ad(2, 1), 0, 0, "R9");
    fl(1, 0, ad(7, 1), 0, 1, 1, 0, 1, 0, "R3");

    // R10: set 2, core 1 holds way 0, core 0 holds ways 1..3
    fl(1, 1, ad(8, 2), 0, 1, 0, 0, 1, 0, "R10");
    for (int t = 9; t <= 11; t++) fl(0, 1, ad(t, 2), 0, 1, t - 8, 0, 1, 0, "R10");
    fl(0, 0, ad(12, 2), 0, 0, 0, 1, 1, 0, "R10");
    e = mk(1, 0, 0, 0, 0, 1, 0, "R10");
    e.exp_binv = 1; e.exp_binvi = 1; e.exp_mask = 1;
    send(4, 0, 1, 0, e);
    fl(0, 0, ad(12, 2), 0, 0, 0, 0, 1, 1, "R10");
    for (int t = 13; t <= 17; t++) fl(0, 0, ad(t, 2), 0, 0, 0, 0, 0, 0, "R10");
    lk(0, 0, ad(8, 2), 1, 0, "R4");
    idle(3);
    check(rsp_valid == 0, "R1", "rsp_valid when idle", rsp_valid, 0);

    // R6: data-only lines in set 3 are not locked
    for (int t = 20; t <= 23; t++) fl(0, 0, ad(t, 3), 0, 1, t - 20, 0, 1, 0, "R6");
    fl(1, 0, ad(24, 3), 0, 0, 0, 0, 1, 1, "R6");
    idle(3);
    hits_seen = 0;
    for (int t = 20; t <= 23; t++) send(0, 1, 0, ad(t, 3), mk(0, 0, 0, 0, 0, 0, 0, "R6"));
    idle(3);
    check(hits_seen == 3, "R6", "surviving lines", hits_seen, 3);
    lk(1, 1, ad(24, 3), 1, 0, "R6");
    q[q.size()-1].chk_way = 0;
    idle(3);
    check(q.size() == 0, "R1", "responses outstanding", q.size(), 0);
    summary();
  end

endmodule